// File: doc/BRIEF.md
# Soft Mute Ramp

This block fades a stereo stream of 24-bit signed samples to silence and back. A shared gain counter scales both channels. Each frame strobe moves the counter one step. While the mute request is high the counter steps down toward zero. While the request is low it steps up toward unity. A request that changes part-way through a ramp turns the ramp around at its current level. The step size stays the same and the gain does not jump.

Each frame strobe registers one scaled left/right pair. The gain used is the value the counter held before that strobe moved it. The sample is multiplied by gain/2^SW and the result is truncated toward zero. A status output shows when the counter is at zero. With the default SW = 10, a full fade in either direction takes 1024 frames.

Top module: `smute_ramp`

## Requirements
- R1: After reset the gain is unity (2^SW). `muted` is low, `out_l` and `out_r` are zero, and `out_valid` is low.
- R2: Each `frame_stb` with `mute_req` high lowers the gain by one, with a floor of zero. Starting from unity, exactly 1024 such strobes (SW = 10) are needed to reach zero.
- R3: Each `frame_stb` with `mute_req` low raises the gain by one, with a ceiling of unity. Starting from zero, exactly 1024 such strobes are needed to reach unity.
- R4: If `mute_req` changes in the middle of a ramp, the gain continues from its current value in the other direction. The step stays at one per strobe.
- R5: One clock after a `frame_stb`, `out_valid` is high for one cycle. The outputs then hold each input multiplied by g/2^SW and truncated toward zero, where g is the gain before that strobe's step.
- R6: Within a frame, the left and right channels are scaled by the same gain.
- R7: `muted` is high exactly when the gain is zero. A frame scaled by a gain of zero gives exactly zero on both channels.
- R8: In a cycle without `frame_stb`, the gain, `out_l`, `out_r` and `muted` do not change, whatever `mute_req` and the sample inputs do.
- R9: A frame scaled by a gain of unity passes both samples through bit-exactly, including the values 0x7FFFFF and 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse, once per stereo frame |
| mute_req | input | 1 | High: fade toward silence; low: fade toward unity |
| in_l | input | DW | Left sample, two's complement |
| in_r | input | DW | Right sample, two's complement |
| out_l | output | DW | Scaled left sample |
| out_r | output | DW | Scaled right sample |
| out_valid | output | 1 | Pulse one cycle after frame_stb |
| muted | output | 1 | High while the gain is zero |

## Verification
Two things happen on the same strobe: the sample is scaled and the gain steps. The sample must be scaled with the gain value from before the step, and `muted` must already show the gain after the step. The bench provokes this on every strobe of the sweeps: the full fade-down, the full fade-up, and a reversal part-way through. Its gain model records the pre-step value, which it uses to predict the outputs, and the post-step value, which it uses to predict `muted`. A design that scales with the stepped gain is then off by one gain step on every frame, and one that updates `muted` late is wrong on the frame where the gain reaches zero.

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int DW = 24,
  parameter int SW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic                 mute_req,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 out_valid,
  output logic                 muted
);
  localparam int GW = SW + 1;
  localparam int PW = DW + GW + 1;
  localparam logic [GW-1:0] UNITY = {1'b1, {SW{1'b0}}};

  logic [GW-1:0] gain;

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] s,
                                                  input logic [GW-1:0] g);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] bias;
    logic signed [PW-1:0] q;
    p    = PW'(s) * PW'($signed({1'b0, g}));
    bias = p[PW-1] ? $signed({{(DW+2){1'b0}}, {SW{1'b1}}}) : '0;
    q    = (p + bias) >>> SW;
    return q[DW-1:0];
  endfunction

  assign muted = (gain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain      <= UNITY;
      out_l     <= '0;
      out_r     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= frame_stb;
      if (frame_stb) begin
        out_l <= scale(in_l, gain);
        out_r <= scale(in_r, gain);
        if (mute_req && gain != '0)
          gain <= gain - GW'(1);
        else if (!mute_req && gain != UNITY)
          gain <= gain + GW'(1);
      end
    end
  end
endmodule

module smute_ramp_chk #(
  parameter int DW = 24,
  parameter int SW = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_stb,
  input logic                 mute_req,
  input logic signed [DW-1:0] in_l,
  input logic signed [DW-1:0] in_r,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 out_valid,
  input logic                 muted,
  input logic [SW:0]          gain
);
  localparam int GW = SW + 1;
  localparam logic [GW-1:0] UNITY = {1'b1, {SW{1'b0}}};

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) gain <= UNITY); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && mute_req && gain != '0 |=> gain == $past(gain) - GW'(1)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && !mute_req && gain != UNITY |=> gain == $past(gain) + GW'(1)); // R3
  AST_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (gain == $past(gain) || gain == $past(gain) + GW'(1) || gain == $past(gain) - GW'(1))); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |=> out_valid); // R5
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && gain == '0 |=> out_l == '0 && out_r == '0); // R7
  AST_MUTED_FLAG: assert property (@(posedge clk) disable iff (!rst_n) muted == (gain == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(gain) && $stable(out_l) && $stable(out_r)); // R8
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && gain == UNITY |=> out_l == $past(in_l) && out_r == $past(in_r)); // R9
endmodule

bind smute_ramp smute_ramp_chk #(.DW(DW), .SW(SW)) u_chk (.*);

// File: tb/smute_ramp_test.sv
module smute_ramp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic mute_req = 1'b0;
  logic signed [23:0] in_l = '0;
  logic signed [23:0] in_r = '0;
  logic signed [23:0] out_l, out_r;
  logic out_valid, muted;

  int checks = 0;
  int errors = 0;
  int g = 1024;
  int k = 0;

  always #10 clk = ~clk;

  smute_ramp uut (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mute_req(mute_req),
                  .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
                  .out_valid(out_valid), .muted(muted));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scale(input logic [23:0] s, input int gv);
    longint p;
    p = longint'($signed(s)) * gv;
    if (p < 0) return -((-p) >>> 10);
    return p >>> 10;
  endfunction

  function automatic logic [23:0] pick(input int n, input int salt);
    case ((n + salt) % 9)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'hFFFFFF;
      3: return 24'h000001;
      default: return 24'((n * 40503 + salt * 7919 + 12345) * 2654435);
    endcase
  endfunction

  task automatic strobe(input bit m, input logic [23:0] l, input logic [23:0] r, input string tag);
    longint el, er;
    @(negedge clk);
    mute_req = m; in_l = l; in_r = r; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    el = scale(l, g);
    er = scale(r, g);
    if (m && g > 0) g--;
    else if (!m && g < 1024) g++;
    check(out_valid == 1'b1, "R5 valid", longint'(out_valid), 1);
    check(longint'(out_l) == el, {tag, " left"}, longint'(out_l), el);
    check(longint'(out_r) == er, {tag, " right R6"}, longint'(out_r), er);
    check(muted == (g == 0), "R7 muted", longint'(muted), longint'(g == 0));
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int steps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(muted == 1'b0, "R1 muted", longint'(muted), 0);
    check(out_l == 0 && out_r == 0, "R1 outputs", longint'(out_l), 0);
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);

    // R9 unity pass-through, including extremes
    strobe(1'b0, 24'h7FFFFF, 24'h800000, "R9");
    check(out_l == 24'h7FFFFF && out_r == 24'h800000, "R9 extremes", longint'(out_l), 24'h7FFFFF);
    for (int i = 0; i < 16; i++) begin
      strobe(1'b0, pick(k, 1), pick(k, 4), "R9"); k++;
    end

    // R2 full fade-down
    steps = 0;
    while (!muted && steps < 1100) begin
      strobe(1'b1, pick(k, 2), pick(k, 5), "R2"); k++; steps++;
    end
    check(steps == 1024, "R2 fade length", steps, 1024);
    // R7 zero gain gives exact zero
    for (int i = 0; i < 6; i++) begin
      strobe(1'b1, pick(k, 0), pick(k, 1), "R7"); k++;
      check(out_l == 0 && out_r == 0, "R7 zero", longint'(out_l), 0);
    end

    // R3 full fade-up
    steps = 0;
    while (g < 1024 && steps < 1100) begin
      strobe(1'b0, pick(k, 3), pick(k, 6), "R3"); k++; steps++;
    end
    check(steps == 1024, "R3 fade length", steps, 1024);

    // R4 reversals mid-ramp
    for (int i = 0; i < 300; i++) begin strobe(1'b1, pick(k, 7), pick(k, 8), "R4"); k++; end
    for (int i = 0; i < 120; i++) begin strobe(1'b0, pick(k, 2), pick(k, 3), "R4"); k++; end
    for (int i = 0; i < 50; i++) begin strobe(1'b1, pick(k, 4), pick(k, 4), "R4"); k++; end
    check(g == 1024 - 300 + 120 - 50, "R4 level", g, 794);
    // R6 equal inputs give equal outputs
    strobe(1'b1, 24'h5A5A5A, 24'h5A5A5A, "R6");
    check(out_l == out_r, "R6 same gain", longint'(out_l), longint'(out_r));

    // R8 idle cycles ignore inputs
    begin
      logic [23:0] hl, hr;
      logic hm;
      hl = out_l; hr = out_r; hm = muted;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        mute_req = i[0]; in_l = pick(i, 3); in_r = pick(i, 7);
        @(negedge clk);
        check(out_l == hl && out_r == hr, "R8 outputs held", longint'(out_l), longint'(hl));
        check(muted == hm && out_valid == 1'b0, "R8 flags held", longint'(muted), longint'(hm));
      end
    end
    strobe(1'b0, 24'h400000, 24'hC00000, "R8 gain held");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule